// File: doc/BRIEF.md
# Clear-on-Read Ethernet Statistics Counter Bank

The block keeps a set of Ethernet statistics counters for each of several ports. The MAC side of every port gives one event strobe per completed frame. The strobe carries the frame length, a direction bit and a vector of per-frame condition flags. From these the block increments event counters, a frame-size histogram for each direction, and wide byte totals. Software reads the counters one word at a time through a simple read port. Any word that is read is cleared in the same cycle, so each read returns the activity since the previous read.

A byte total is wider than a data word, so it is stored as a low word with the high word at the next offset. Reading the low word returns the low half. The same read copies the high half into a holding register and zeroes the whole total. A following read of the high word then returns a half that matches the low half already read. No event is lost when it arrives in the same cycle as a read of its counter. Counters stop at all ones and never wrap.

Top module: `mib_stats_bank`

## Requirements
- R1: The byte address of a word is `port*0x100 + word*4`, and address bits [1:0] are ignored. A read request on `rd_en` gives `rd_valid` high and the data on `rd_data` on the next clock edge.
- R2: The receive words, by byte offset, are: 0x00 broadcast, 0x04 pause, 0x08 multicast, 0x0c FCS error, 0x10 alignment error, 0x14 runt, 0x18 fragment, 0x1c..0x34 size bins, 0x38 too-long, 0x3c/0x40 good bytes low/high, 0x44/0x48 bad bytes low/high, 0x4c overflow, 0x50 filtered.
- R3: The transmit words, by byte offset, are: 0x54 broadcast, 0x58 pause, 0x5c multicast, 0x60 underrun, 0x64..0x7c size bins, 0x80 oversize, 0x84/0x88 bytes low/high, 0x8c collision, 0x90 abort-collision, 0x94 multiple-collision, 0x98 single-collision, 0x9c excessive defer, 0xa0 defer, 0xa4 late collision.
- R4: The event flag bits are: 0 broadcast, 1 multicast, 2 pause, 7 too-long (receive) or oversize (transmit); for receive only, 3 FCS, 4 alignment, 5 runt, 6 fragment, 8 overflow, 9 filtered; for transmit only, 10 underrun, 11 collision, 12 abort-collision, 13 multiple-collision, 14 single-collision, 15 excessive defer, 16 defer, 17 late collision. `ev_tx`=1 marks a transmit event. A flag that belongs to the other direction has no effect.
- R5: Each event increments exactly one size bin of its own direction. The bins, in ascending offset order, are: length <=64, 65..127, 128..255, 256..511, 512..1023, 1024..1518, and >1518.
- R6: A receive event adds its length to the bad-byte total when any of flags 3,4,5,6,7,8 is set, and to the good-byte total otherwise. Every transmit event adds its length to the transmit byte total.
- R7: Reading a word returns its value and clears it.
- R8: Reading the low word of a byte total returns the low half, latches the high half and clears the whole total. Reading the high word returns the latched half and clears the latch.
- R9: When an increment and a read of the same counter fall in the same cycle, the read returns the old value and the counter keeps the new increment.
- R10: Counters saturate at all ones. A byte total saturates as one double-width value, with both words all ones.
- R11: A read with a word offset above 0xa4, or with a port number of NUM_PORTS or more, returns zero and changes no counter. `rd_data` is zero whenever `rd_valid` is low.
- R12: After reset every counter reads zero and `rd_valid` is low.
- R13: Events on one port never change the counters of another port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | NUM_PORTS | Per-port frame event strobe |
| ev_tx | input | NUM_PORTS | Per-port direction, 1 = transmit |
| ev_len | input | NUM_PORTS*LEN_W | Per-port frame length in bytes |
| ev_flags | input | NUM_PORTS*18 | Per-port condition flags |
| rd_en | input | 1 | Read request |
| rd_addr | input | PORT_W+8 | Byte address of the word to read |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | WORD_W | Read data |

## Verification
The bench goes after the bin edges at 64/65 and 1518/1519. A decoder with an off-by-one threshold would put one of those frames in the neighbouring bin. It issues a read and an increment in the same cycle. A design that cleared after updating would lose the event, and one that ignored the clear would return the same count twice. It lets new bytes arrive between the low and high reads of a split total. A design without the latch would return a high half that does not match the low half already read. It drives counters and byte totals past full scale, where a wrapping counter would read back small. Finally it sends flags for the wrong direction, reads out-of-range addresses and reads a second port, where a loose decode would show up as stray nonzero counts.

// File: rtl/mib_stats_pkg.sv
package mib_stats_pkg;
    localparam int NUM_WORDS = 42;           // 0x00..0xa4
    localparam int IDX_W     = 6;
    localparam int NUM_BINS  = 7;
    localparam int NUM_WIDE  = 3;            // good rx, bad rx, tx bytes
    localparam int FLAG_W    = 18;

    // word indices (offset / 4)
    localparam int RX_BCAST = 0,  RX_PAUSE = 1,  RX_MCAST = 2,  RX_FCS = 3;
    localparam int RX_ALIGN = 4,  RX_RUNT  = 5,  RX_FRAG  = 6,  RX_BIN0 = 7;
    localparam int RX_LONG  = 14, RX_GOOD  = 15, RX_BAD   = 17, RX_OVF  = 19;
    localparam int RX_FILT  = 20;
    localparam int TX_BCAST = 21, TX_PAUSE = 22, TX_MCAST = 23, TX_UNDR = 24;
    localparam int TX_BIN0  = 25, TX_OVSZ  = 32, TX_BYTES = 33, TX_COLL = 35;

    // flag bit positions
    localparam int F_BCAST = 0, F_MCAST = 1, F_PAUSE = 2, F_FCS = 3;
    localparam int F_ALIGN = 4, F_RUNT  = 5, F_FRAG  = 6, F_LONG = 7;
    localparam int F_OVF   = 8, F_FILT  = 9, F_UNDR  = 10, F_COLL = 11;

    function automatic int wide_lo(input int k);
        case (k)
            0:       return RX_GOOD;
            1:       return RX_BAD;
            default: return TX_BYTES;
        endcase
    endfunction
endpackage

// File: rtl/mib_event_decode.sv
module mib_event_decode
    import mib_stats_pkg::*;
#(
    parameter int LEN_W = 14
) (
    input  logic                                ev_valid,
    input  logic                                ev_tx,
    input  logic [LEN_W-1:0]                    ev_len,
    input  logic [FLAG_W-1:0]                   ev_flags,
    output logic [NUM_WORDS-1:0]                inc_mask,
    output logic [NUM_WIDE-1:0][LEN_W-1:0]      byte_add
);
    logic [31:0] len32;
    logic [2:0]  bin;
    logic        rx_err;

    always_comb begin
        len32 = 32'(ev_len);
        if      (len32 <= 32'd64)   bin = 3'd0;
        else if (len32 <= 32'd127)  bin = 3'd1;
        else if (len32 <= 32'd255)  bin = 3'd2;
        else if (len32 <= 32'd511)  bin = 3'd3;
        else if (len32 <= 32'd1023) bin = 3'd4;
        else if (len32 <= 32'd1518) bin = 3'd5;
        else                        bin = 3'd6;

        rx_err = ev_flags[F_FCS] | ev_flags[F_ALIGN] | ev_flags[F_RUNT] |
                 ev_flags[F_FRAG] | ev_flags[F_LONG] | ev_flags[F_OVF];

        inc_mask = '0;
        byte_add = '0;
        if (ev_valid && !ev_tx) begin
            inc_mask[RX_BCAST]     = ev_flags[F_BCAST];
            inc_mask[RX_PAUSE]     = ev_flags[F_PAUSE];
            inc_mask[RX_MCAST]     = ev_flags[F_MCAST];
            inc_mask[RX_FCS]       = ev_flags[F_FCS];
            inc_mask[RX_ALIGN]     = ev_flags[F_ALIGN];
            inc_mask[RX_RUNT]      = ev_flags[F_RUNT];
            inc_mask[RX_FRAG]      = ev_flags[F_FRAG];
            inc_mask[RX_BIN0+int'(bin)] = 1'b1;
            inc_mask[RX_LONG]      = ev_flags[F_LONG];
            inc_mask[RX_OVF]       = ev_flags[F_OVF];
            inc_mask[RX_FILT]      = ev_flags[F_FILT];
            if (rx_err) byte_add[1] = ev_len;
            else        byte_add[0] = ev_len;
        end else if (ev_valid) begin
            inc_mask[TX_BCAST]     = ev_flags[F_BCAST];
            inc_mask[TX_PAUSE]     = ev_flags[F_PAUSE];
            inc_mask[TX_MCAST]     = ev_flags[F_MCAST];
            inc_mask[TX_UNDR]      = ev_flags[F_UNDR];
            inc_mask[TX_BIN0+int'(bin)] = 1'b1;
            inc_mask[TX_OVSZ]      = ev_flags[F_LONG];
            for (int j = 0; j < 7; j++) begin
                inc_mask[TX_COLL+j] = ev_flags[F_COLL+j];
            end
            byte_add[2] = ev_len;
        end
    end
endmodule

// File: rtl/mib_port_bank.sv
module mib_port_bank
    import mib_stats_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int LEN_W  = 14
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_WORDS-1:0]            inc_mask,
    input  logic [NUM_WIDE-1:0][LEN_W-1:0]  byte_add,
    input  logic                            rd_hit,
    input  logic [IDX_W-1:0]                rd_idx,
    output logic [WORD_W-1:0]               rd_word
);
    localparam int DW = 2 * WORD_W;

    typedef struct packed {
        logic [NUM_WORDS-1:0][WORD_W-1:0] cnt;
        logic [NUM_WIDE-1:0][WORD_W-1:0]  shadow;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        logic [WORD_W-1:0] base;
        logic [DW-1:0]     wide;
        logic [DW:0]       sum;
        int                lo;
        bank_d = bank_q;
        for (int i = 0; i < NUM_WORDS; i++) begin
            base = (rd_hit && rd_idx == IDX_W'(i)) ? '0 : bank_q.cnt[i];
            bank_d.cnt[i] = (inc_mask[i] && base != '1) ? base + 1'b1 : base;
        end
        for (int k = 0; k < NUM_WIDE; k++) begin
            lo   = wide_lo(k);
            wide = (rd_hit && rd_idx == IDX_W'(lo)) ? '0
                   : {bank_q.cnt[lo+1], bank_q.cnt[lo]};
            sum  = {1'b0, wide} + (DW+1)'(byte_add[k]);
            if (sum[DW]) sum[DW-1:0] = '1;
            {bank_d.cnt[lo+1], bank_d.cnt[lo]} = sum[DW-1:0];
            if (rd_hit && rd_idx == IDX_W'(lo))
                bank_d.shadow[k] = bank_q.cnt[lo+1];
            else if (rd_hit && rd_idx == IDX_W'(lo+1))
                bank_d.shadow[k] = '0;
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < NUM_WORDS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_word = bank_q.cnt[i];
        end
        for (int k = 0; k < NUM_WIDE; k++) begin
            if (rd_idx == IDX_W'(wide_lo(k) + 1)) rd_word = bank_q.shadow[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // R7
    clear_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_idx == IDX_W'(RX_BCAST) && !inc_mask[RX_BCAST])
        |=> bank_q.cnt[RX_BCAST] == '0);

    // R10
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q.cnt[RX_BCAST] == '1 && !(rd_hit && rd_idx == IDX_W'(RX_BCAST)))
        |=> bank_q.cnt[RX_BCAST] == '1);

    // R8
    high_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && rd_idx == IDX_W'(RX_GOOD))
        |=> bank_q.shadow[0] == $past(bank_q.cnt[RX_GOOD+1]));

    // R5
    one_bin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(inc_mask[RX_BIN0+NUM_BINS-1:RX_BIN0]) <= 1 &&
        $countones(inc_mask[TX_BIN0+NUM_BINS-1:TX_BIN0]) <= 1);
endmodule

// File: rtl/mib_stats_bank.sv
module mib_stats_bank
    import mib_stats_pkg::*;
#(
    parameter int NUM_PORTS = 2,
    parameter int WORD_W    = 32,
    parameter int LEN_W     = 14,
    localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
    localparam int ADDR_W   = PORT_W + 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_PORTS-1:0]          ev_valid,
    input  logic [NUM_PORTS-1:0]          ev_tx,
    input  logic [NUM_PORTS*LEN_W-1:0]    ev_len,
    input  logic [NUM_PORTS*FLAG_W-1:0]   ev_flags,
    input  logic                          rd_en,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic                          rd_valid,
    output logic [WORD_W-1:0]             rd_data
);
    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] data;
    } rd_t;

    rd_t                          rd_d, rd_q;
    logic [PORT_W-1:0]            rd_port;
    logic [IDX_W-1:0]             rd_idx;
    logic                         addr_ok;
    logic [NUM_PORTS-1:0][WORD_W-1:0] port_word;

    assign rd_port = rd_addr[ADDR_W-1:8];
    assign rd_idx  = rd_addr[7:2];
    assign addr_ok = (32'(rd_port) < NUM_PORTS) && (32'(rd_idx) < NUM_WORDS);

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [NUM_WORDS-1:0]           inc_mask;
        logic [NUM_WIDE-1:0][LEN_W-1:0] byte_add;

        mib_event_decode #(.LEN_W(LEN_W)) dec_i (
            .ev_valid (ev_valid[g]),
            .ev_tx    (ev_tx[g]),
            .ev_len   (ev_len[g*LEN_W +: LEN_W]),
            .ev_flags (ev_flags[g*FLAG_W +: FLAG_W]),
            .inc_mask (inc_mask),
            .byte_add (byte_add)
        );

        mib_port_bank #(.WORD_W(WORD_W), .LEN_W(LEN_W)) bank_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .inc_mask (inc_mask),
            .byte_add (byte_add),
            .rd_hit   (rd_en && addr_ok && rd_port == PORT_W'(g)),
            .rd_idx   (rd_idx),
            .rd_word  (port_word[g])
        );
    end

    always_comb begin
        rd_d.valid = rd_en;
        rd_d.data  = '0;
        if (rd_en && addr_ok) begin
            for (int p = 0; p < NUM_PORTS; p++) begin
                if (rd_port == PORT_W'(p)) rd_d.data = port_word[p];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_valid = rd_q.valid;
    assign rd_data  = rd_q.data;

    // R1
    rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R1
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    // R11
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> rd_data == '0);
endmodule

// File: tb/mib_stats_bank_tb.sv
module mib_stats_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 2, WW = 8, LW = 14, FW = 18, AW = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     ev_valid = '0;
    logic [NP-1:0]     ev_tx = '0;
    logic [NP*LW-1:0]  ev_len = '0;
    logic [NP*FW-1:0]  ev_flags = '0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     rd_addr = '0;
    logic              rd_valid;
    logic [WW-1:0]     rd_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mib_stats_bank #(.NUM_PORTS(NP), .WORD_W(WW), .LEN_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_tx(ev_tx),
        .ev_len(ev_len), .ev_flags(ev_flags), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data));

    typedef struct packed {
        logic          port;
        logic          tx;
        logic [13:0]   len;
        logic [17:0]   flags;
        logic [8:0]    addr;
        logic [7:0]    exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, 14'd64,   18'h00001, 9'h000, 8'd1},   // R2 rx bcast
        {1'b0, 1'b0, 14'd100,  18'h00002, 9'h008, 8'd1},   // R2 rx mcast
        {1'b0, 1'b0, 14'd64,   18'h00004, 9'h004, 8'd1},   // R2 rx pause
        {1'b0, 1'b0, 14'd70,   18'h00008, 9'h00c, 8'd1},   // R2 rx fcs
        {1'b0, 1'b0, 14'd64,   18'h00000, 9'h01c, 8'd1},   // R5 bin <=64
        {1'b0, 1'b0, 14'd65,   18'h00000, 9'h020, 8'd1},   // R5 bin 65..127
        {1'b0, 1'b0, 14'd1518, 18'h00000, 9'h030, 8'd1},   // R5 bin 1024..1518
        {1'b0, 1'b0, 14'd1519, 18'h00000, 9'h034, 8'd1},   // R5 bin >1518
        {1'b0, 1'b0, 14'd100,  18'h00000, 9'h03c, 8'd100}, // R6 good bytes
        {1'b0, 1'b0, 14'd300,  18'h00008, 9'h044, 8'd44},  // R6 bad bytes low
        {1'b0, 1'b1, 14'd512,  18'h00000, 9'h074, 8'd1},   // R3 tx bin 512..1023
        {1'b0, 1'b1, 14'd200,  18'h00800, 9'h08c, 8'd1},   // R3 tx collision
        {1'b0, 1'b1, 14'd64,   18'h20000, 9'h0a4, 8'd1},   // R3 tx late collision
        {1'b0, 1'b1, 14'd300,  18'h00000, 9'h084, 8'd44},  // R6 tx bytes low
        {1'b0, 1'b0, 14'd64,   18'h00200, 9'h050, 8'd1},   // R2 rx filtered
        {1'b0, 1'b1, 14'd64,   18'h00400, 9'h060, 8'd1},   // R3 tx underrun
        {1'b1, 1'b0, 14'd64,   18'h00100, 9'h14c, 8'd1},   // R13 port1 overflow
        {1'b0, 1'b0, 14'd2000, 18'h00080, 9'h038, 8'd1}    // R2 rx too-long
    };

    task automatic chk(input string req, input logic [WW-1:0] got,
                       input logic [WW-1:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic send_ev(input int p, input logic tx, input int len,
                           input logic [FW-1:0] fl);
        @(negedge clk);
        ev_valid[p] = 1'b1;
        ev_tx[p] = tx;
        ev_len[p*LW +: LW] = LW'(len);
        ev_flags[p*FW +: FW] = fl;
        @(negedge clk);
        ev_valid = '0;
        ev_flags = '0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [WW-1:0] d);
        @(negedge clk);
        rd_en = 1'b1;
        rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
        d = rd_data;
    endtask

    task automatic clear_all();
        logic [WW-1:0] d;
        for (int p = 0; p < NP; p++) begin
            for (int w = 0; w < 42; w++) rd(AW'(p*256 + w*4), d);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [WW-1:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        chk("R12 rd_valid", WW'(rd_valid), '0);
        rd(9'h000, d); chk("R12 rx bcast", d, 0);
        rd(9'h1a4, d); chk("R12 port1 late col", d, 0);

        // R1 latency: valid only one cycle after request
        @(negedge clk); rd_en = 1'b1; rd_addr = 9'h000;
        chk("R1 no early valid", WW'(rd_valid), 0);
        @(negedge clk); rd_en = 1'b0;
        chk("R1 valid next cycle", WW'(rd_valid), 1);

        // table walk
        for (int v = 0; v < NV; v++) begin
            clear_all();
            send_ev(int'(VECS[v].port), VECS[v].tx, int'(VECS[v].len),
                    VECS[v].flags);
            rd(VECS[v].addr, d);
            chk($sformatf("R2/R3/R5/R6 vector %0d", v), d, VECS[v].exp);
        end

        // R8 split byte total with traffic between low and high reads
        clear_all();
        send_ev(0, 1'b0, 300, '0);
        rd(9'h03c, d); chk("R8 low word", d, 44);
        send_ev(0, 1'b0, 10, '0);
        rd(9'h040, d); chk("R8 latched high", d, 1);
        rd(9'h040, d); chk("R8 latch cleared", d, 0);
        rd(9'h03c, d); chk("R8 new low", d, 10);

        // R9 increment in the same cycle as the read
        clear_all();
        send_ev(0, 1'b0, 64, 18'h1);
        send_ev(0, 1'b0, 64, 18'h1);
        @(negedge clk);
        ev_valid[0] = 1'b1; ev_tx[0] = 1'b0;
        ev_len[0 +: LW] = 14'd64; ev_flags[0 +: FW] = 18'h1;
        rd_en = 1'b1; rd_addr = 9'h000;
        @(negedge clk);
        ev_valid = '0; ev_flags = '0; rd_en = 1'b0;
        chk("R9 old value returned", rd_data, 2);
        rd(9'h000, d); chk("R9 increment kept", d, 1);
        rd(9'h000, d); chk("R7 cleared by read", d, 0);

        // R10 saturation
        clear_all();
        for (int n = 0; n < 260; n++) send_ev(0, 1'b0, 64, 18'h1);
        rd(9'h000, d); chk("R10 counter saturates", d, 8'hff);
        clear_all();
        for (int n = 0; n < 45; n++) send_ev(0, 1'b0, 1500, '0);
        rd(9'h03c, d); chk("R10 wide low saturates", d, 8'hff);
        rd(9'h040, d); chk("R10 wide high saturates", d, 8'hff);

        // R11 out-of-range read has no effect
        clear_all();
        send_ev(0, 1'b0, 64, 18'h1);
        rd(9'h0a8, d); chk("R11 offset 0xa8 zero", d, 0);
        rd(9'h0fc, d); chk("R11 offset 0xfc zero", d, 0);
        rd(9'h000, d); chk("R11 counter untouched", d, 1);

        // R4 flags of the other direction ignored
        clear_all();
        send_ev(0, 1'b1, 64, 18'h00108);
        rd(9'h00c, d); chk("R4 tx fcs ignored", d, 0);
        rd(9'h04c, d); chk("R4 tx overflow ignored", d, 0);
        rd(9'h01c, d); chk("R4 rx bin untouched", d, 0);
        rd(9'h064, d); chk("R4 tx bin counted", d, 1);
        send_ev(0, 1'b0, 64, 18'h00c00);
        rd(9'h060, d); chk("R4 rx underrun ignored", d, 0);
        rd(9'h08c, d); chk("R4 rx collision ignored", d, 0);

        // R13 port isolation
        clear_all();
        send_ev(1, 1'b0, 64, 18'h1);
        rd(9'h000, d); chk("R13 port0 unchanged", d, 0);
        rd(9'h100, d); chk("R13 port1 counted", d, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule